// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block sequences a pulse-swallow feedback divider so that its average ratio carries a fraction. It runs on the prescaler output clock, one clock per prescaler period. Each output cycle lasts B prescaler periods. During the first A' of them the block asks the prescaler to divide by P+1, and during the rest by P. A' is the programmed swallow count A plus the carry of a first-order accumulator. The accumulator adds the fractional numerator FN once per output cycle, modulo M.

Two run-time selects shape the arithmetic. The reference select sets M to 1920 or 1968. The band select sets P to 8 or 6, which also limits the largest legal A. Settings are taken only where one output cycle ends and the next begins. Out-of-range settings are clamped to the nearest legal value and flagged for the cycle that uses them.

Top module: `fracn_divctl`

## Requirements
- R1: During reset and in the first clock after it, mod_ctl, div_out and cfg_err are 0 and pre_eight is 1. The first output cycle after reset lasts 2 periods with mod_ctl low.
- R2: Every output cycle lasts exactly B (clamped) input periods, and div_out is 1 only in its last period.
- R3: mod_ctl is 1 (divide by P+1) for the first A' periods of an output cycle and 0 for the rest. It never returns to 1 inside a cycle. A' is the clamped A plus the accumulator carry of that cycle.
- R4: Once per output cycle the accumulator adds the clamped FN modulo M, where M is 1920 with ref_sel=0 and 1968 with ref_sel=1, and a wrap gives a carry of 1. When ref_sel differs from the value taken at the previous boundary, the accumulator restarts from zero before the add. With fixed settings, any M consecutive cycles hold exactly FN carries.
- R5: band_sel=0 selects P=8, which allows A up to 7. band_sel=1 selects P=6, which allows A up to 5. pre_eight shows the P of the current cycle (1 means 8).
- R6: b_in, a_in, fn_in, ref_sel and band_sel are sampled only at the clock edge that ends the last period of a cycle. Changes at any other time do not alter the cycle in progress.
- R7: B below 2 is raised to 2. A above its band limit is lowered to the limit, and an A not below B is lowered to B-1. FN not below M is lowered to M-1. cfg_err is 1 for exactly the cycles that use a setting which needed any of these corrections.
- R8: The VCO periods in an output cycle, counting P+1 for each period with mod_ctl high and P otherwise, total P·B + A'. With M=1920, P=6, B=11, A=4 and FN=1104, 1920 cycles give 1920·70 + 1104.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock, one edge per prescaler period |
| rst_n | input | 1 | Active-low synchronous reset |
| b_in | input | 4 | Programmable counter value B |
| a_in | input | 3 | Swallow counter value A |
| fn_in | input | 11 | Fractional numerator FN |
| ref_sel | input | 1 | Modulus select: 0 gives 1920, 1 gives 1968 |
| band_sel | input | 1 | Prescaler select: 0 gives P=8, 1 gives P=6 |
| mod_ctl | output | 1 | 1 asks the prescaler to divide by P+1 |
| div_out | output | 1 | High in the last period of each output cycle |
| pre_eight | output | 1 | P of the current cycle, 1 for 8 and 0 for 6 |
| cfg_err | output | 1 | Current cycle runs on clamped settings |

## Verification
A wrong period counter shows up within one output cycle, as a div_out pulse at the wrong distance from the one before it. A wrong latched swallow count or carry shows up as a wrong number of mod_ctl periods in that same cycle. A corrupted accumulator residue may hide for many cycles and only show as a wrong carry count over a full modulus window. For that reason the fraction is checked by summing over exactly M cycles, in both modulus settings.

// File: rtl/fracn_divctl.sv
module fracn_divctl #(
  parameter int BW     = 4,
  parameter int AW     = 3,
  parameter int FW     = 11,
  parameter int MOD_LO = 1920,
  parameter int MOD_HI = 1968
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] b_in,
  input  logic [AW-1:0] a_in,
  input  logic [FW-1:0] fn_in,
  input  logic          ref_sel,
  input  logic          band_sel,
  output logic          mod_ctl,
  output logic          div_out,
  output logic          pre_eight,
  output logic          cfg_err
);
  localparam int SW = FW + 1;
  localparam logic [BW-1:0] B_MIN  = BW'(2);
  localparam logic [AW-1:0] A_TOP8 = '1;
  localparam logic [AW-1:0] A_TOP6 = A_TOP8 - AW'(2);
  localparam logic [SW-1:0] M_LO   = SW'(MOD_LO);
  localparam logic [SW-1:0] M_HI   = SW'(MOD_HI);

  logic [BW-1:0] cnt, b_l, aeff;
  logic [SW-1:0] acc;
  logic          ref_l;

  logic [SW-1:0] m_sel, fn_x, fn_c, base, sum, acc_n;
  logic [AW-1:0] a_top, a_1;
  logic [BW-1:0] b_c, a_1x, a_c;
  logic          carry, bad, last;

  assign m_sel = ref_sel ? M_HI : M_LO;
  assign a_top = band_sel ? A_TOP6 : A_TOP8;
  assign b_c   = (b_in < B_MIN) ? B_MIN : b_in;
  assign a_1   = (a_in > a_top) ? a_top : a_in;
  assign a_1x  = BW'(a_1);
  assign a_c   = (a_1x >= b_c) ? b_c - BW'(1) : a_1x;
  assign fn_x  = SW'(fn_in);
  assign fn_c  = (fn_x >= m_sel) ? m_sel - SW'(1) : fn_x;
  assign base  = (ref_sel == ref_l) ? acc : '0;
  assign sum   = base + fn_c;
  assign carry = (sum >= m_sel);
  assign acc_n = carry ? sum - m_sel : sum;
  assign bad   = (b_in < B_MIN) || (a_in > a_top) || (a_1x >= b_c) || (fn_x >= m_sel);

  assign last    = (cnt == b_l - BW'(1));
  assign div_out = last;
  assign mod_ctl = (cnt < aeff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      b_l       <= B_MIN;
      aeff      <= '0;
      acc       <= '0;
      ref_l     <= 1'b0;
      pre_eight <= 1'b1;
      cfg_err   <= 1'b0;
    end else if (last) begin
      cnt       <= '0;
      b_l       <= b_c;
      aeff      <= a_c + BW'(carry);
      acc       <= acc_n;
      ref_l     <= ref_sel;
      pre_eight <= ~band_sel;
      cfg_err   <= bad;
    end else begin
      cnt <= cnt + BW'(1);
    end
  end

  a_r2_cnt_below_b: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < b_l);

  a_r3_swallow_fits: assert property (@(posedge clk) disable iff (!rst_n)
    aeff <= b_l);

  a_r3_ctl_no_return: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_ctl && !div_out) |=> !mod_ctl);

  a_r4_acc_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    acc < (ref_l ? M_HI : M_LO));

  a_r6_hold_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !div_out |=> ($stable(b_l) && $stable(aeff) && $stable(pre_eight)));

  a_r7_err_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_err) |-> $past(div_out));
endmodule

// File: tb/fracn_divctl_tb_top.sv
module fracn_divctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] b_in = 4'd2;
  logic [2:0] a_in = 3'd0;
  logic [10:0] fn_in = 11'd0;
  logic ref_sel = 1'b0, band_sel = 1'b0;
  logic mod_ctl, div_out, pre_eight, cfg_err;

  always #10 clk = ~clk;

  fracn_divctl dut_i (
    .clk(clk), .rst_n(rst_n), .b_in(b_in), .a_in(a_in), .fn_in(fn_in),
    .ref_sel(ref_sel), .band_sel(band_sel), .mod_ctl(mod_ctl),
    .div_out(div_out), .pre_eight(pre_eight), .cfg_err(cfg_err)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mod_of(input bit r); return r ? 1968 : 1920; endfunction
  function automatic int top_of(input bit bs); return bs ? 5 : 7; endfunction
  function automatic int b_fix(input int b); return (b < 2) ? 2 : b; endfunction
  function automatic int a_fix(input int a, input int b, input bit bs);
    int x = (a > top_of(bs)) ? top_of(bs) : a;
    return (x >= b_fix(b)) ? b_fix(b) - 1 : x;
  endfunction
  function automatic int fn_fix(input int f, input bit r);
    return (f >= mod_of(r)) ? mod_of(r) - 1 : f;
  endfunction
  function automatic bit is_bad(input int b, input int a, input int f, input bit r, input bit bs);
    return (b < 2) || (a > top_of(bs)) || (a >= b) || (f >= mod_of(r));
  endfunction

  // bench model of the current cycle
  int macc = 0; bit mref = 0;
  int e_b = 2, e_aeff = 0; bit e_p8 = 1, e_err = 0;
  bit pend = 0;
  int per = 0, hi = 0, vco = 0; bit seen_low = 0, order_bad = 0;
  longint cyc = 0, hi_total = 0, vco_total = 0;

  always @(posedge clk) begin
    if (rst_n && pend) begin
      int m, f, s; bit c;
      m = mod_of(ref_sel);
      f = fn_fix(int'(fn_in), ref_sel);
      if (ref_sel != mref) macc = 0;
      s = macc + f;
      c = (s >= m);
      macc = c ? s - m : s;
      mref = ref_sel;
      e_b = b_fix(int'(b_in));
      e_aeff = a_fix(int'(a_in), int'(b_in), band_sel) + int'(c);
      e_p8 = ~band_sel;
      e_err = is_bad(int'(b_in), int'(a_in), int'(fn_in), ref_sel, band_sel);
      pend = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      per++;
      vco += mod_ctl ? ((e_p8 ? 8 : 6) + 1) : (e_p8 ? 8 : 6);
      if (mod_ctl) begin
        hi++;
        if (seen_low) order_bad = 1;
      end else seen_low = 1;
      if (!div_out && per >= e_b) chk(0, "R2 div_out missing at period", per, e_b);
      if (div_out) begin
        chk(per == e_b, "R2 cycle length", per, e_b);
        chk(hi == e_aeff, "R3 swallow periods", hi, e_aeff);
        chk(!order_bad, "R3 mod_ctl order", order_bad, 0);
        chk(vco == (e_p8 ? 8 : 6) * e_b + e_aeff, "R8 vco periods", vco, (e_p8 ? 8 : 6) * e_b + e_aeff);
        chk(pre_eight == e_p8, "R5 pre_eight", pre_eight, e_p8);
        chk(cfg_err == e_err, "R7 cfg_err", cfg_err, e_err);
        cyc++; hi_total += hi; vco_total += vco;
        per = 0; hi = 0; vco = 0; seen_low = 0; order_bad = 0;
        pend = 1;
      end
    end
  end

  task automatic wait_cycles(input int n);
    longint t = cyc + n;
    while (cyc < t) @(posedge clk);
  endtask

  task automatic set_cfg(input int b, input int a, input int f, input bit r, input bit bs);
    @(negedge clk);
    b_in = 4'(b); a_in = 3'(a); fn_in = 11'(f); ref_sel = r; band_sel = bs;
  endtask

  task automatic window(input int m, input int p, input int b, input int a, input int f);
    longint h0, v0;
    wait_cycles(2);
    h0 = hi_total; v0 = vco_total;
    wait_cycles(m);
    chk(hi_total - h0 == longint'(m) * a + f, "R4 carries over modulus window",
        int'(hi_total - h0 - longint'(m) * a), f);
    chk(vco_total - v0 == longint'(m) * (p * b + a) + f, "R8 average ratio",
        int'(vco_total - v0), m * (p * b + a) + f);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(mod_ctl == 0 && div_out == 0 && cfg_err == 0 && pre_eight == 1, "R1 reset outputs",
        {mod_ctl, div_out, cfg_err, pre_eight}, 1);
    @(posedge clk); #5 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(mod_ctl == 0 && div_out == 0 && cfg_err == 0 && pre_eight == 1, "R1 first period",
        {mod_ctl, div_out, cfg_err, pre_eight}, 1);
    @(negedge clk); #1;
    chk(div_out == 1 && mod_ctl == 0, "R1 first cycle of 2 periods", {div_out, mod_ctl}, 2);

    // sample setting, P=6, M=1920
    set_cfg(11, 4, 1104, 0, 1);
    window(1920, 6, 11, 4, 1104);
    // P=8, M=1968, largest values
    set_cfg(15, 7, 1967, 1, 0);
    window(1968, 8, 15, 7, 1967);
    // A = B-1 with carries: all periods slow
    set_cfg(3, 2, 1919, 0, 0);
    wait_cycles(40);
    // invalid settings (R7), band limit (R5)
    set_cfg(1, 0, 0, 0, 0);    wait_cycles(4);
    set_cfg(5, 5, 300, 0, 0);  wait_cycles(4);
    set_cfg(12, 7, 10, 0, 1);  wait_cycles(4);
    set_cfg(9, 3, 2000, 0, 0); wait_cycles(4);
    set_cfg(9, 3, 2047, 1, 1); wait_cycles(4);
    set_cfg(9, 3, 100, 1, 1);  wait_cycles(4);

    // random settings changed at arbitrary points (R6)
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(5) == 0) begin
        b_in = 4'($urandom_range(15));
        a_in = 3'($urandom_range(7));
        fn_in = ($urandom_range(4) == 0) ? 11'($urandom_range(2047)) : 11'($urandom_range(1919));
        ref_sel = 1'($urandom_range(1));
        band_sel = 1'($urandom_range(1));
      end
    end
    wait_cycles(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule